// File: doc/BRIEF.md
# Parameter-Set Link Reload Engine

This block keeps a small parameter memory for a DMA channel controller. The memory is divided into fixed sets of eight 32-bit words. When a channel has submitted every transfer that its active set describes, the channel sends a completion request that carries the index of that set. The engine then refreshes the set from another set. The source is chosen by a 16-bit link field stored inside the active set. The link field holds a byte address in the parameter map: sets are 32 bytes apart and start at `MAP_BASE`, which is 4000h by default.

The refresh depends on what the active set contains. A set with its hold bit set is left untouched. A link value of FFFFh makes the engine write a synthesized null set instead of copying one. A set may link to itself, which gives an automatically repeating transfer. When the refreshed set belongs to a queued channel, the completed overwrite counts as a write to its trigger word, and the engine emits a trigger pulse for that set.

A host port reads and writes single words. Host accesses have lower priority than the engine and stall while a reload is running.

Top module: `plink_reload`

## Requirements
- R1: After reset `cmp_ready` is 1, and `done`, `trig` and `err` are 0.
- R2: A host access is accepted in a cycle where `host_req` and `host_ack` are both 1. A write stores `host_wdata` at word `host_addr`, where the address is {set index, word index[2:0]}. A read returns that word on `host_rdata` in the cycle after acceptance.
- R3: A completion request on a set whose link field is a valid set address copies all 8 words of the source set into the active set. The link field is bits [15:0] of word 5, and the valid address of set k is MAP_BASE + 32·k.
- R4: When bit 3 of word 0 of the active set (the hold bit) is 1, the engine leaves the set unchanged and signals `done` without `trig` or `err`.
- R5: A link field of FFFFh overwrites the active set with zeros in every word except word 5, which becomes 0000FFFFh.
- R6: A set whose link field points to itself holds the same 8 words after the reload as before it.
- R7: A link address that is below MAP_BASE, not a multiple of 32 bytes from MAP_BASE, or beyond the last set raises `err` together with `done`, and the set is left unchanged.
- R8: `trig` pulses together with `done`, with `trig_set` equal to the active set, only when the set was overwritten (copy or null) and `qmap` marks that set. A held set or an error gives no trigger.
- R9: From the cycle a request is accepted until `done`, `cmp_ready` is 0 and `host_ack` stays 0 even while `host_req` is 1.
- R10: `done` is a one-cycle pulse, and `cmp_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address {set, word} |
| host_wdata | input | DATA_W | Host write data |
| host_ack | output | 1 | Host access accepted this cycle |
| host_rdata | output | DATA_W | Read data, valid the cycle after acceptance |
| cmp_valid | input | 1 | Completion request for an exhausted set |
| cmp_set | input | SET_W | Index of the exhausted set |
| cmp_ready | output | 1 | Engine idle and able to accept a request |
| qmap | input | NUM_SETS | One flag per set: set is mapped to a queued channel |
| done | output | 1 | Reload finished (one-cycle pulse) |
| trig | output | 1 | Trigger event to latch for `trig_set` |
| trig_set | output | SET_W | Set index that the trigger belongs to |
| err | output | 1 | Bad link address, no copy made |

## Verification
Most internal faults in this engine show up as wrong memory contents. Examples are a link field that is re-read after the copy has started, a source index decoded with the wrong offset, or a buffer slot written out of order. These errors become visible at the host port as soon as the `done` pulse ends, on the first read of the affected set. A sequencer that picks the wrong path (hold, null, error or copy) is caught earlier, in the `done` cycle itself, because `trig` and `err` are sampled there. An engine that stays busy is visible at once as `cmp_ready` and `host_ack` held low.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int unsigned SET_WORDS = 8;
  localparam int unsigned WIDX_W    = 3;
  localparam logic [2:0]  OPT_WORD  = 3'd0;
  localparam logic [2:0]  LINK_WORD = 3'd5;
  localparam int unsigned HOLD_BIT  = 3;
  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR0, S_HDR1, S_DEC, S_RD, S_WR, S_NUL, S_FIN
  } rl_state_e;
endpackage

// File: rtl/plink_mem.sv
module plink_mem #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/plink_decode.sv
module plink_decode #(
  parameter int unsigned NUM_SETS = 16,
  parameter logic [15:0] MAP_BASE = 16'h4000,
  parameter int unsigned SET_W    = 4
) (
  input  logic [15:0]      link,
  output logic             is_null,
  output logic             is_valid,
  output logic [SET_W-1:0] src_set
);
  localparam logic [15:0] SETS16 = 16'(NUM_SETS);
  logic [15:0] off;

  always_comb begin
    off      = link - MAP_BASE;
    is_null  = (link == plink_pkg::NULL_LINK);
    is_valid = (link >= MAP_BASE) && (off[4:0] == 5'd0) &&
               ({5'd0, off[15:5]} < SETS16);
    src_set  = off[SET_W+4:5];
  end
endmodule

// File: rtl/plink_ctrl.sv
module plink_ctrl
  import plink_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SET_W    = 4,
  parameter int unsigned ADDR_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  input  logic [SET_W-1:0]    cmp_set,
  output logic                cmp_ready,
  input  logic [NUM_SETS-1:0] qmap,
  output logic [ADDR_W-1:0]   mem_raddr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_waddr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [15:0]         link_q,
  input  logic                dec_null,
  input  logic                dec_valid,
  input  logic [SET_W-1:0]    dec_src,
  output logic                done,
  output logic                trig,
  output logic [SET_W-1:0]    trig_set,
  output logic                err
);
  rl_state_e         state_q, state_d;
  logic [WIDX_W-1:0] cnt_q, cnt_d;
  logic [SET_W-1:0]  dst_q;
  logic              hold_q, wrote_q, wrote_d, err_q, err_d;
  logic [DATA_W-1:0] buf_q [SET_WORDS];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wrote_d = wrote_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: if (cmp_valid) begin
        state_d = S_HDR0; wrote_d = 1'b0; err_d = 1'b0;
      end
      S_HDR0: state_d = S_HDR1;
      S_HDR1: state_d = S_DEC;
      S_DEC: begin
        cnt_d = '0;
        if (hold_q)          state_d = S_FIN;
        else if (dec_null)   state_d = S_NUL;
        else if (!dec_valid) begin state_d = S_FIN; err_d = 1'b1; end
        else                 state_d = S_RD;
      end
      S_RD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 3'd7) state_d = S_WR;
      end
      S_WR, S_NUL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 3'd7) begin state_d = S_FIN; wrote_d = 1'b1; end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wrote_q <= 1'b0;
      err_q   <= 1'b0;
      dst_q   <= '0;
      hold_q  <= 1'b0;
      link_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wrote_q <= wrote_d;
      err_q   <= err_d;
      if (state_q == S_IDLE && cmp_valid) dst_q  <= cmp_set;
      if (state_q == S_HDR0)              hold_q <= mem_rdata[HOLD_BIT];
      if (state_q == S_HDR1)              link_q <= mem_rdata[15:0];
    end
  end

  // Staging buffer: the whole source set is read before any word is written
  always_ff @(posedge clk) begin
    if (state_q == S_RD) buf_q[cnt_q] <= mem_rdata;
  end

  always_comb begin
    unique case (state_q)
      S_HDR0:  mem_raddr = {dst_q, OPT_WORD};
      S_HDR1:  mem_raddr = {dst_q, LINK_WORD};
      default: mem_raddr = {dec_src, cnt_q};
    endcase
    mem_we    = (state_q == S_WR) || (state_q == S_NUL);
    mem_waddr = {dst_q, cnt_q};
    if (state_q == S_NUL)
      mem_wdata = (cnt_q == LINK_WORD) ? DATA_W'(NULL_LINK) : '0;
    else
      mem_wdata = buf_q[cnt_q];
  end

  assign cmp_ready = (state_q == S_IDLE);
  assign done      = (state_q == S_FIN);
  assign err       = done && err_q;
  assign trig      = done && wrote_q && qmap[dst_q];
  assign trig_set  = dst_q;
endmodule

// File: rtl/plink_reload.sv
module plink_reload #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [15:0] MAP_BASE = 16'h4000,
  parameter int unsigned SET_W    = $clog2(NUM_SETS),
  parameter int unsigned ADDR_W   = SET_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                host_ack,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic                cmp_valid,
  input  logic [SET_W-1:0]    cmp_set,
  output logic                cmp_ready,
  input  logic [NUM_SETS-1:0] qmap,
  output logic                done,
  output logic                trig,
  output logic [SET_W-1:0]    trig_set,
  output logic                err
);
  localparam int unsigned DEPTH = NUM_SETS * plink_pkg::SET_WORDS;

  logic [ADDR_W-1:0] eng_raddr, eng_waddr, waddr;
  logic [DATA_W-1:0] eng_rdata, eng_wdata, wdata, host_rd;
  logic              eng_we, we;
  logic [15:0]       link_q;
  logic              dec_null, dec_valid;
  logic [SET_W-1:0]  dec_src;

  // The engine has priority: a request it accepts this cycle blocks the host
  assign host_ack = host_req && cmp_ready && !cmp_valid;
  assign we       = eng_we || (host_ack && host_we);
  assign waddr    = eng_we ? eng_waddr : host_addr;
  assign wdata    = eng_we ? eng_wdata : host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      host_rdata <= '0;
    else if (host_ack && !host_we)   host_rdata <= host_rd;
  end

  plink_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(eng_raddr), .rdata_a(eng_rdata),
    .raddr_b(host_addr), .rdata_b(host_rd)
  );

  plink_decode #(.NUM_SETS(NUM_SETS), .MAP_BASE(MAP_BASE), .SET_W(SET_W)) u_dec (
    .link(link_q), .is_null(dec_null), .is_valid(dec_valid), .src_set(dec_src)
  );

  plink_ctrl #(.NUM_SETS(NUM_SETS), .DATA_W(DATA_W), .SET_W(SET_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_set(cmp_set),
    .cmp_ready(cmp_ready), .qmap(qmap),
    .mem_raddr(eng_raddr), .mem_rdata(eng_rdata), .mem_we(eng_we),
    .mem_waddr(eng_waddr), .mem_wdata(eng_wdata), .link_q(link_q),
    .dec_null(dec_null), .dec_valid(dec_valid), .dec_src(dec_src),
    .done(done), .trig(trig), .trig_set(trig_set), .err(err)
  );
endmodule

// File: rtl/plink_reload_chk.sv
module plink_reload_chk (
  input logic clk,
  input logic rst_n,
  input logic host_req,
  input logic host_ack,
  input logic cmp_valid,
  input logic cmp_ready,
  input logic done,
  input logic trig,
  input logic err
);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready) |=> !cmp_ready);
  // R9
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ready |-> !host_ack);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmp_ready));
  // R8
  trig_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (done && !err));
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> host_req);
endmodule

bind plink_reload plink_reload_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ack(host_ack),
  .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .done(done),
  .trig(trig), .err(err)
);

// File: tb/plink_reload_bench.sv
`timescale 1ns/1ps
module plink_reload_bench;
  localparam int NS = 16;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic host_ack;
  logic cmp_valid;
  logic [SW-1:0] cmp_set;
  logic cmp_ready;
  logic [NS-1:0] qmap;
  logic done, trig, err;
  logic [SW-1:0] trig_set;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  plink_reload u_plink_reload (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .cmp_valid(cmp_valid), .cmp_set(cmp_set),
    .cmp_ready(cmp_ready), .qmap(qmap), .done(done), .trig(trig),
    .trig_set(trig_set), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fillw(input int k, input int w);
    return 32'hA000_0000 | (k << 8) | w;
  endfunction

  function automatic logic [15:0] laddr(input int k);
    return 16'h4000 + 16'(k * 32);
  endfunction

  task automatic hwrite(input int s, input int w, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(s * 8 + w); host_wdata = d;
    #1;
    while (!host_ack) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input int s, input int w, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = AW'(s * 8 + w);
    #1;
    while (!host_ack) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    host_req = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  // Fill a set with its pattern, then set its option word and its link word
  task automatic load_set(input int s, input logic [31:0] opt, input logic [15:0] lnk);
    for (int w = 0; w < 8; w++) hwrite(s, w, fillw(s, w));
    hwrite(s, 0, opt);
    hwrite(s, 5, {16'h0, lnk});
  endtask

  // Issue a completion request and wait for done; R9/R10 checked on the way
  task automatic reload(input int s, output logic t, output logic e, output logic [SW-1:0] ts);
    logic busy_ok;
    logic seen;
    busy_ok = 1'b1; seen = 1'b0;
    t = 1'b0; e = 1'b0; ts = '0;
    @(negedge clk);
    cmp_valid = 1'b1; cmp_set = SW'(s);
    @(posedge clk); #1;
    cmp_valid = 1'b0;
    host_req = 1'b1; host_we = 1'b0; host_addr = '0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) begin
        t = trig; e = err; ts = trig_set; seen = 1'b1;
        break;
      end
      if (cmp_ready || host_ack) busy_ok = 1'b0;
    end
    host_req = 1'b0;
    check("R9 busy: ready and host_ack low", {31'd0, busy_ok}, 32'd1);
    check("R10 done seen", {31'd0, seen}, 32'd1);
    @(negedge clk);
    check("R10 done is one cycle", {31'd0, done}, 32'd0);
    check("R10 ready back", {31'd0, cmp_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 ready", {31'd0, cmp_ready}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 trig", {31'd0, trig}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_host_rw();
    logic [31:0] d;
    hwrite(1, 3, 32'h1234_5678);
    hwrite(1, 4, 32'hCAFE_F00D);
    hread(1, 3, d); check("R2 read back w3", d, 32'h1234_5678);
    hread(1, 4, d); check("R2 read back w4", d, 32'hCAFE_F00D);
  endtask

  task automatic t_copy();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(5, 32'h0, 16'h1111);
    load_set(2, 32'h0, laddr(5));
    reload(2, t, e, ts);
    check("R8 no trig for unmapped copy", {31'd0, t}, 32'd0);
    check("R3 no err", {31'd0, e}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] exp;
      exp = (w == 0) ? 32'h0 : (w == 5) ? 32'h0000_1111 : fillw(5, w);
      hread(2, w, d); check("R3 copied word", d, exp);
    end
  endtask

  task automatic t_static();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(3, 32'h0000_0008, laddr(5));
    reload(3, t, e, ts);
    check("R4 no trig on held set", {31'd0, t}, 32'd0);
    check("R4 no err on held set", {31'd0, e}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] exp;
      exp = (w == 0) ? 32'h8 : (w == 5) ? {16'h0, laddr(5)} : fillw(3, w);
      hread(3, w, d); check("R4 held set unchanged", d, exp);
    end
  endtask

  task automatic t_null();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(4, 32'h0, 16'hFFFF);
    reload(4, t, e, ts);
    check("R5 no err", {31'd0, e}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      hread(4, w, d);
      check("R5 null set word", d, (w == 5) ? 32'h0000_FFFF : 32'h0);
    end
  endtask

  task automatic t_self();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(6, 32'h0000_0010, laddr(6));
    reload(6, t, e, ts);
    check("R8 trig on mapped self-link", {31'd0, t}, 32'd1);
    check("R8 trig_set", {28'd0, ts}, 32'd6);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] exp;
      exp = (w == 0) ? 32'h10 : (w == 5) ? {16'h0, laddr(6)} : fillw(6, w);
      hread(6, w, d); check("R6 self-linked set intact", d, exp);
    end
  endtask

  task automatic t_error();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(7, 32'h0, laddr(5) + 16'd4);
    reload(7, t, e, ts);
    check("R7 misaligned err", {31'd0, e}, 32'd1);
    check("R8 no trig on err", {31'd0, t}, 32'd0);
    hread(7, 2, d); check("R7 set unchanged", d, fillw(7, 2));
    load_set(8, 32'h0, laddr(16));
    reload(8, t, e, ts);
    check("R7 out of range err", {31'd0, e}, 32'd1);
    hread(8, 6, d); check("R7 set unchanged", d, fillw(8, 6));
    load_set(11, 32'h0, 16'h0020);
    reload(11, t, e, ts);
    check("R7 below base err", {31'd0, e}, 32'd1);
  endtask

  task automatic t_qdma();
    logic t, e; logic [SW-1:0] ts; logic [31:0] d;
    load_set(9, 32'h0, laddr(5));
    reload(9, t, e, ts);
    check("R8 trig on mapped copy", {31'd0, t}, 32'd1);
    check("R8 trig_set", {28'd0, ts}, 32'd9);
    hread(9, 7, d); check("R3 mapped copy word", d, fillw(5, 7));
    load_set(12, 32'h0, 16'hFFFF);
    reload(12, t, e, ts);
    check("R8 trig on mapped null", {31'd0, t}, 32'd1);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    cmp_valid = 1'b0; cmp_set = '0;
    qmap = '0;
    qmap[3] = 1'b1; qmap[6] = 1'b1; qmap[7] = 1'b1; qmap[9] = 1'b1; qmap[12] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_rw();
    t_copy();
    t_static();
    t_null();
    t_self();
    t_error();
    t_qdma();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule